// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional Pairs

This block keeps track of address reservations for a fixed number of hardware contexts. A context reserves an address with a load-locked operation. Later it tries a store-conditional to the same address. The store succeeds only if no write to that address has happened in the meantime. The block holds one reservation slot per context. A slot is indexed directly by context ID and stores a valid flag and the address reduced to reservation granularity.

Every write the memory side performs, plain or conditional, is shown to the block on a write-observe port. In the same cycle the block answers with a success bit. That write removes every reservation on the same granule, whoever made it. A store-conditional also needs its own context to still hold a matching reservation at that moment. Load-locked updates and invalidations take effect on the next rising clock edge. At most one operation (load-locked or write) is presented per cycle.

Top module: `resv_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drops every reservation, so a store-conditional presented after reset reports 0.
- R2: A load-locked from a context with no reservation creates one for that context, which takes effect from the next clock edge on.
- R3: A context owns at most one reservation; a new load-locked from it replaces the stored granule, so only the newest address can satisfy its store-conditional.
- R4: Addresses are reduced to granules of 2^GRAN_LOG2 bytes before storing and comparing; with the default of 8-byte granules, addresses 0x1000 and 0x1007 match while 0x1008 does not.
- R5: Any write (plain, `wr_cond`=0, or conditional, `wr_cond`=1) invalidates every reservation on its granule, for all contexts at once.
- R6: A plain write always reports `wr_ok`=1, with or without reservations.
- R7: A store-conditional reports `wr_ok`=1 only if its own context holds a valid reservation on the write's granule. A reservation held by another context does not count.
- R8: A store-conditional removes its own matching reservation, so a second store-conditional to the same granule fails.
- R9: Writes to other granules leave a reservation intact, including a failed store-conditional to a different granule from the owning context.
- R10: `wr_ok` is combinational, valid in the same cycle as `wr_valid`, and is 0 whenever `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ll_valid | input | 1 | Load-locked operation present this cycle |
| ll_ctx | input | CTX_W | Context issuing the load-locked |
| ll_addr | input | ADDR_W | Physical address of the load-locked |
| wr_valid | input | 1 | Write operation present this cycle |
| wr_ctx | input | CTX_W | Context issuing the write |
| wr_addr | input | ADDR_W | Physical address of the write |
| wr_cond | input | 1 | 1 = store-conditional, 0 = plain store |
| wr_ok | output | 1 | Write outcome: 1 success, 0 failure (0 when idle) |

## Verification
One conditional write does two things at the same edge. It decides its own success from the requesting context's slot, and it clears every other context's slot on the same granule. The bench provokes this by reserving one granule from two contexts and then issuing a store-conditional from one of them. It expects that store to report 1 and the other context's later store-conditional to report 0. A second case pairs a foreign store-conditional (expected 0) with the loss of the owner's reservation, which shows up as 0 on the owner's next attempt.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic {
    WR_PLAIN = 1'b0,
    WR_COND  = 1'b1
  } wr_kind_e;

  // Outcome of a write given whether the requester still owns a matching slot.
  function automatic logic store_verdict(input wr_kind_e kind, input logic own_hit);
    return (kind == WR_PLAIN) ? 1'b1 : own_hit;
  endfunction

endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
  parameter int TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             vld,
  output logic             hit
);

  logic [TAG_W-1:0] tag_q;

  assign hit = vld && (tag_q == wr_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= 1'b0;
      tag_q <= '0;
    end else if (set_en) begin
      vld   <= 1'b1;
      tag_q <= set_tag;
    end else if (wr_valid && hit) begin
      vld <= 1'b0;
    end
  end

endmodule

// File: rtl/resv_scan.sv
module resv_scan #(
  parameter int N_CTX = 4,
  parameter int CTX_W = 2
) (
  input  logic [N_CTX-1:0] hit_vec,
  input  logic             wr_valid,
  input  logic             wr_cond,
  input  logic [CTX_W-1:0] wr_ctx,
  output logic             own_hit,
  output logic             wr_ok
);

  import resv_pkg::*;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < N_CTX; i++) begin
      if (wr_ctx == CTX_W'(i) && hit_vec[i]) own_hit = 1'b1;
    end
  end

  assign wr_ok = wr_valid && store_verdict(wr_kind_e'(wr_cond), own_hit);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int N_CTX    = 4,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LOG2 = 3,
  localparam int CTX_W   = $clog2(N_CTX),
  localparam int TAG_W   = ADDR_W - GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [CTX_W-1:0]  ll_ctx,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              wr_valid,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_cond,
  output logic              wr_ok
);

  function automatic logic [TAG_W-1:0] granule(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:GRAN_LOG2];
  endfunction

  logic [TAG_W-1:0] ll_tag;
  logic [TAG_W-1:0] wr_tag;
  logic [N_CTX-1:0] ll_sel;
  logic [N_CTX-1:0] vld_vec;
  logic [N_CTX-1:0] hit_vec;
  logic             own_hit;

  assign ll_tag = granule(ll_addr);
  assign wr_tag = granule(wr_addr);

  for (genvar i = 0; i < N_CTX; i++) begin : g_slot
    assign ll_sel[i] = ll_valid && (ll_ctx == CTX_W'(i));

    resv_slot #(.TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .set_en   (ll_sel[i]),
      .set_tag  (ll_tag),
      .wr_valid (wr_valid),
      .wr_tag   (wr_tag),
      .vld      (vld_vec[i]),
      .hit      (hit_vec[i])
    );
  end

  resv_scan #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_scan (
    .hit_vec  (hit_vec),
    .wr_valid (wr_valid),
    .wr_cond  (wr_cond),
    .wr_ctx   (wr_ctx),
    .own_hit  (own_hit),
    .wr_ok    (wr_ok)
  );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int N_CTX = 4,
  parameter int CTX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ll_valid,
  input logic [CTX_W-1:0] ll_ctx,
  input logic             wr_valid,
  input logic [CTX_W-1:0] wr_ctx,
  input logic             wr_cond,
  input logic             wr_ok,
  input logic             own_hit,
  input logic [N_CTX-1:0] vld_vec,
  input logic [N_CTX-1:0] hit_vec
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (vld_vec == '0));

  assert_plain_ok_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_cond) |-> wr_ok);

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> !wr_ok);

  assert_hit_implies_own_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_cond && own_hit) |-> wr_ok);

  for (genvar i = 0; i < N_CTX; i++) begin : g_chk
    assert_ll_allocates_R2: assert property (@(posedge clk) disable iff (rst)
      (ll_valid && ll_ctx == CTX_W'(i)) |=> vld_vec[i]);

    assert_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && hit_vec[i] && !(ll_valid && ll_ctx == CTX_W'(i))) |=> !vld_vec[i]);

    assert_sc_owner_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_cond && wr_ok && wr_ctx == CTX_W'(i)) |-> vld_vec[i]);
  end

endmodule

bind resv_monitor resv_monitor_chk #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ll_valid (ll_valid),
  .ll_ctx   (ll_ctx),
  .wr_valid (wr_valid),
  .wr_ctx   (wr_ctx),
  .wr_cond  (wr_cond),
  .wr_ok    (wr_ok),
  .own_hit  (own_hit),
  .vld_vec  (vld_vec),
  .hit_vec  (hit_vec)
);

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int N_CTX  = 4;
  localparam int ADDR_W = 32;
  localparam int CTX_W  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ll_valid = 1'b0;
  logic [CTX_W-1:0]  ll_ctx = '0;
  logic [ADDR_W-1:0] ll_addr = '0;
  logic              wr_valid = 1'b0;
  logic [CTX_W-1:0]  wr_ctx = '0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic              wr_cond = 1'b0;
  logic              wr_ok;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor #(.N_CTX(N_CTX), .ADDR_W(ADDR_W), .GRAN_LOG2(3)) dut (
    .clk(clk), .rst(rst),
    .ll_valid(ll_valid), .ll_ctx(ll_ctx), .ll_addr(ll_addr),
    .wr_valid(wr_valid), .wr_ctx(wr_ctx), .wr_addr(wr_addr),
    .wr_cond(wr_cond), .wr_ok(wr_ok)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: wr_ok=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic idle();
    ll_valid = 1'b0; wr_valid = 1'b0; wr_cond = 1'b0;
  endtask

  task automatic do_ll(input int ctx, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    ll_valid = 1'b1; ll_ctx = CTX_W'(ctx); ll_addr = a;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_wr(input int ctx, input logic [ADDR_W-1:0] a, input logic cond,
                       input logic exp, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_ctx = CTX_W'(ctx); wr_addr = a; wr_cond = cond;
    #1;
    check(wr_ok, exp, req);
    @(posedge clk); #1;
    idle();
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  // R1, R10: empty table after reset, idle output low
  task automatic t_reset();
    @(negedge clk); #1;
    check(wr_ok, 1'b0, "R10 idle");
    do_wr(0, 32'h100, 1'b1, 1'b0, "R1 sc after reset");
  endtask

  // R2, R8
  task automatic t_alloc();
    do_ll(1, 32'h200);
    do_wr(1, 32'h200, 1'b1, 1'b1, "R2 sc after ll");
    do_wr(1, 32'h200, 1'b1, 1'b0, "R8 second sc");
  endtask

  // R3
  task automatic t_replace();
    do_ll(2, 32'h300);
    do_ll(2, 32'h400);
    do_wr(2, 32'h300, 1'b1, 1'b0, "R3 old addr");
    do_wr(2, 32'h400, 1'b1, 1'b1, "R3 new addr");
  endtask

  // R4, R9
  task automatic t_mask();
    do_ll(0, 32'h1000);
    do_wr(0, 32'h1007, 1'b1, 1'b1, "R4 same granule");
    do_ll(0, 32'h1000);
    do_wr(0, 32'h1008, 1'b1, 1'b0, "R4 next granule");
    do_wr(0, 32'h1000, 1'b1, 1'b1, "R9 survives other-granule sc");
  endtask

  // R6
  task automatic t_plain();
    do_wr(3, 32'h50, 1'b0, 1'b1, "R6 plain no resv");
  endtask

  // R5, R9, R6: shared granule cleared for all, other granule kept
  task automatic t_multi();
    do_ll(0, 32'h2000);
    do_ll(1, 32'h2004);
    do_ll(2, 32'h3000);
    do_wr(3, 32'h2000, 1'b0, 1'b1, "R6 plain with resv");
    do_wr(0, 32'h2000, 1'b1, 1'b0, "R5 ctx0 cleared");
    do_wr(1, 32'h2000, 1'b1, 1'b0, "R5 ctx1 cleared");
    do_wr(2, 32'h3000, 1'b1, 1'b1, "R9 ctx2 kept");
  endtask

  // R7: foreign sc fails and still clears the owner
  task automatic t_foreign();
    do_ll(0, 32'h4000);
    do_wr(1, 32'h4000, 1'b1, 1'b0, "R7 foreign sc");
    do_wr(0, 32'h4000, 1'b1, 1'b0, "R5 owner lost to foreign sc");
  endtask

  // R5 + R7 in the same cycle: own success, other context cleared
  task automatic t_same_cycle();
    do_ll(0, 32'h5000);
    do_ll(1, 32'h5000);
    do_wr(1, 32'h5000, 1'b1, 1'b1, "R7 own sc");
    do_wr(0, 32'h5000, 1'b1, 1'b0, "R5 sibling cleared");
  endtask

  // R1 mid-run
  task automatic t_reset_mid();
    do_ll(3, 32'h6000);
    pulse_reset();
    do_wr(3, 32'h6000, 1'b1, 1'b0, "R1 reset mid-run");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: timeout reached");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alloc();
    t_replace();
    t_mask();
    t_plain();
    t_multi();
    t_foreign();
    t_same_cycle();
    t_reset_mid();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule